// File: doc/BRIEF.md
# Static Memory Read Timing Generator

This block runs single read accesses to an external asynchronous static memory or memory-mapped peripheral on a parallel bus. When a request is accepted, the block registers the external address and then opens a timed window. Inside that window it drives an active-low read strobe and one of six active-low chip-select lines. Each of the two strobes has its own setup, pulse and hold counts. All counts are in controller clock cycles and are measured from the first cycle of the access.

A separate total-length count sets how long the access occupies the bus. If either strobe's setup, pulse and hold together need more cycles than that count gives, the access is stretched so that hold time is never cut short. The 16-bit data bus is sampled on the last clock edge before the read strobe returns high. The sampled word is handed back with a one-cycle valid pulse.

The address seen by the device depends on its width. A byte-wide device gets the byte address as it is. A halfword-wide device gets the byte address shifted right by one, so its lowest address pin carries byte-address bit 1. Timing values and the device width are static inputs, held steady while the block is busy.

Top module: `smem_rd_timer`

## Requirements
- R1: After reset, `busy` is 0, `mem_rd_n` is 1, every `mem_cs_n` bit is 1 and `rdata_valid` is 0. This holds whatever access was in progress when reset was applied.
- R2: A request (`req_valid`=1 while `busy`=0) is accepted at a rising clock edge. `busy` is then 1 for exactly L cycles, starting with the cycle after that edge. L = max(cycle length, rd setup+pulse+hold, cs setup+pulse+hold, 1), where a zero pulse counts as 1. Access cycles are numbered t=0..L-1, with t=0 the first cycle in which `busy` is 1.
- R3: In cycle t=0, `mem_addr` shows the mapped address. It keeps that value through the access and afterwards, until the next accepted request. For a byte-wide device (`cfg_dev16`=0), `mem_addr` equals `req_addr`.
- R4: For a halfword-wide device (`cfg_dev16`=1), `mem_addr` equals `req_addr` shifted right by one bit, with a 0 shifted in at the top.
- R5: `mem_rd_n` is 0 exactly in cycles t where rd setup <= t < rd setup + rd pulse. At all other times it is 1.
- R6: Bit n of `mem_cs_n` is 0 exactly in cycles t where cs setup <= t < cs setup + cs pulse, and only when `req_cs` was n (n from 0 to 5). The other bits stay 1. A `req_cs` of 6 or 7 asserts no line.
- R7: A pulse count of 0, for either strobe, behaves as a pulse count of 1.
- R8: `mem_data_in` is sampled at the clock edge that ends cycle t = rd setup + rd pulse - 1. `rdata_valid` is 1 for the single cycle t = rd setup + rd pulse, and in that cycle `rdata` holds the sampled word. `rdata` keeps the word afterwards.
- R9: When a strobe's setup+pulse+hold exceeds the programmed cycle length, `busy` lasts for that larger span instead.
- R10: A request raised while `busy` is 1 is dropped. It does not change `mem_addr`, the selected line or the strobe timing, and no access follows for it once `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_addr | input | 24 | Byte address of the request |
| req_cs | input | 3 | Chip-select index, 0 to 5 |
| cfg_dev16 | input | 1 | 1 selects halfword-wide device address mapping |
| cfg_rd_setup | input | 6 | Read strobe setup cycles |
| cfg_rd_pulse | input | 6 | Read strobe pulse cycles (0 acts as 1) |
| cfg_rd_hold | input | 6 | Read strobe hold cycles |
| cfg_cs_setup | input | 6 | Chip-select setup cycles |
| cfg_cs_pulse | input | 6 | Chip-select pulse cycles (0 acts as 1) |
| cfg_cs_hold | input | 6 | Chip-select hold cycles |
| cfg_cycle | input | 6 | Total access length in cycles |
| busy | output | 1 | Access in progress |
| mem_addr | output | 24 | External address bus |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_cs_n | output | 6 | Active-low chip selects |
| mem_data_in | input | 16 | External data bus |
| rdata | output | 16 | Captured read data |
| rdata_valid | output | 1 | One-cycle pulse when `rdata` is new |

## Verification
The bench drives zero setup and zero pulse counts. A design that treats a zero pulse as "no strobe" would never assert the strobe and would return no data. A design whose counts are off by one would shift every strobe edge and the capture cycle, and the bench checks strobe levels and data in every cycle of each access.

Accesses whose strobe spans exceed the cycle length show whether the busy window is stretched. Truncating it would drop `busy` before the hold ends. One access is one cycle long, so its data-valid pulse lands after `busy` has already fallen.

Requests held high for the whole busy window, carrying a different address and line, catch a design that re-latches the address or starts a phantom access. Halfword mapping of an all-ones address and an out-of-range chip-select index complete the set.

// File: rtl/smem_rd_pkg.sv
// Shared types for the static memory read timing generator.
// Assumes nothing beyond standard SystemVerilog.
package smem_rd_pkg;

    // Access sequencer state: idle, or running through an access.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_st_e;

endpackage

// File: rtl/smem_rd_seq.sv
// Access sequencer. Accepts a request while idle, then counts access
// cycles t = 0 .. len-1 and returns to idle. Also exports the next-cycle
// count and activity, so downstream output flops can be registered
// without a cycle of lag.
// Assumes len >= 1 and stays steady during an access.
module smem_rd_seq
    import smem_rd_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [TW-1:0] len,
    output logic          accept,
    output logic          active,
    output logic [TW-1:0] t_cur,
    output logic          act_nxt,
    output logic [TW-1:0] t_nxt
);

    seq_st_e       st_q;
    logic [TW-1:0] t_q;
    logic          at_end;

    // Next-state decode: accept when idle, advance while running, stop at the end.
    always_comb begin
        accept  = req_valid && (st_q == SEQ_IDLE);
        at_end  = (st_q == SEQ_RUN) && ((t_q + 1'b1) == len);
        act_nxt = 1'b0;
        t_nxt   = '0;
        if (accept) begin
            act_nxt = 1'b1;
            t_nxt   = '0;
        end else if ((st_q == SEQ_RUN) && !at_end) begin
            act_nxt = 1'b1;
            t_nxt   = t_q + 1'b1;
        end
    end

    // State and cycle counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEQ_IDLE;
            t_q  <= '0;
        end else begin
            st_q <= act_nxt ? SEQ_RUN : SEQ_IDLE;
            t_q  <= t_nxt;
        end
    end

    assign active = (st_q == SEQ_RUN);
    assign t_cur  = t_q;

endmodule

// File: rtl/smem_rd_win.sv
// Strobe window calculator. From a setup, pulse and hold triple it works
// out whether the strobe is on in the next cycle, the full span the
// strobe needs, and whether the current cycle is the strobe's last on
// cycle. A zero pulse is widened to one cycle.
// Assumes the counts stay steady during an access and TW >= CNT_W + 2.
module smem_rd_win #(
    parameter int CNT_W = 6,
    parameter int TW    = CNT_W + 2
) (
    input  logic [CNT_W-1:0] setup,
    input  logic [CNT_W-1:0] pulse,
    input  logic [CNT_W-1:0] hold,
    input  logic             active,
    input  logic [TW-1:0]    t_cur,
    input  logic             act_nxt,
    input  logic [TW-1:0]    t_nxt,
    output logic             on_nxt,
    output logic             last_on,
    output logic [TW-1:0]    span
);

    localparam int PADW = TW - CNT_W;

    logic [TW-1:0] start_t;
    logic [TW-1:0] pulse_eff;
    logic [TW-1:0] stop_t;

    // Window edges: start at setup, stop after the (floored) pulse, span includes hold.
    always_comb begin
        start_t   = {{PADW{1'b0}}, setup};
        pulse_eff = (pulse == '0) ? TW'(1) : {{PADW{1'b0}}, pulse};
        stop_t    = start_t + pulse_eff;
        span      = stop_t + {{PADW{1'b0}}, hold};
        on_nxt    = act_nxt && (t_nxt >= start_t) && (t_nxt < stop_t);
        last_on   = active && (t_cur == (stop_t - 1'b1));
    end

endmodule

// File: rtl/smem_rd_addr.sv
// External address register. Loads the mapped address when a request is
// accepted and holds it until the next one. Halfword devices get the byte
// address shifted right by one bit.
// Assumes the width select is steady at the load edge.
module smem_rd_addr #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              dev16,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    logic [ADDR_W-1:0] mapped;

    // Width-dependent mapping of the byte address onto the device pins.
    always_comb begin
        mapped = dev16 ? {1'b0, addr_in[ADDR_W-1:1]} : addr_in;
    end

    // Address hold register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out <= '0;
        end else if (load) begin
            addr_out <= mapped;
        end
    end

endmodule

// File: rtl/smem_rd_timer.sv
// Static memory read timing generator (top). Runs one read access per
// accepted request. Read strobe and chip select follow their own
// setup/pulse/hold windows inside a total length that is stretched to
// cover the longer strobe span. All pin outputs come straight from flops.
// Assumes the cfg_* inputs are steady while busy is high.
module smem_rd_timer #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int NUM_CS = 6,
    parameter int CNT_W  = 6,
    parameter int CS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    input  logic              cfg_dev16,
    input  logic [CNT_W-1:0]  cfg_rd_setup,
    input  logic [CNT_W-1:0]  cfg_rd_pulse,
    input  logic [CNT_W-1:0]  cfg_rd_hold,
    input  logic [CNT_W-1:0]  cfg_cs_setup,
    input  logic [CNT_W-1:0]  cfg_cs_pulse,
    input  logic [CNT_W-1:0]  cfg_cs_hold,
    input  logic [CNT_W-1:0]  cfg_cycle,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_n,
    output logic [NUM_CS-1:0] mem_cs_n,
    input  logic [DATA_W-1:0] mem_data_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);

    localparam int TW   = CNT_W + 2;
    localparam int PADW = TW - CNT_W;

    logic          accept;
    logic          active;
    logic [TW-1:0] t_cur;
    logic          act_nxt;
    logic [TW-1:0] t_nxt;
    logic [TW-1:0] len;
    logic [TW-1:0] cyc_eff;
    logic [TW-1:0] rd_span;
    logic [TW-1:0] cs_span;
    logic [TW-1:0] span_max;
    logic          rd_on_nxt;
    logic          rd_last_on;
    logic          cs_on_nxt;
    logic          cs_last_unused;
    logic [CS_W-1:0] sel_q;
    logic [CS_W-1:0] sel_nxt;
    logic          rd_n_q;
    logic [NUM_CS-1:0] cs_n_q;
    logic [DATA_W-1:0] rdata_q;
    logic          dv_q;

    // Access length: largest of the cycle count and both strobe spans.
    always_comb begin
        cyc_eff  = (cfg_cycle == '0) ? TW'(1) : {{PADW{1'b0}}, cfg_cycle};
        span_max = (rd_span > cs_span) ? rd_span : cs_span;
        len      = (span_max > cyc_eff) ? span_max : cyc_eff;
    end

    smem_rd_seq #(.TW(TW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .len       (len),
        .accept    (accept),
        .active    (active),
        .t_cur     (t_cur),
        .act_nxt   (act_nxt),
        .t_nxt     (t_nxt)
    );

    smem_rd_win #(.CNT_W(CNT_W), .TW(TW)) u_rd_win (
        .setup   (cfg_rd_setup),
        .pulse   (cfg_rd_pulse),
        .hold    (cfg_rd_hold),
        .active  (active),
        .t_cur   (t_cur),
        .act_nxt (act_nxt),
        .t_nxt   (t_nxt),
        .on_nxt  (rd_on_nxt),
        .last_on (rd_last_on),
        .span    (rd_span)
    );

    smem_rd_win #(.CNT_W(CNT_W), .TW(TW)) u_cs_win (
        .setup   (cfg_cs_setup),
        .pulse   (cfg_cs_pulse),
        .hold    (cfg_cs_hold),
        .active  (active),
        .t_cur   (t_cur),
        .act_nxt (act_nxt),
        .t_nxt   (t_nxt),
        .on_nxt  (cs_on_nxt),
        .last_on (cs_last_unused),
        .span    (cs_span)
    );

    smem_rd_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .dev16    (cfg_dev16),
        .addr_in  (req_addr),
        .addr_out (mem_addr)
    );

    // Select index for the coming cycle: the new request's on accept, else the held one.
    always_comb begin
        sel_nxt = accept ? req_cs : sel_q;
    end

    // Select index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_nxt;
        end
    end

    // Read strobe flop, driven from the next-cycle window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_n_q <= 1'b1;
        end else begin
            rd_n_q <= !rd_on_nxt;
        end
    end

    // One flop per chip-select line; only the selected index can go low.
    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cs_n_q[gi] <= 1'b1;
            end else begin
                cs_n_q[gi] <= !(cs_on_nxt && (sel_nxt == CS_W'(gi)));
            end
        end
    end

    // Data capture on the last strobe-on edge, plus the one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            dv_q    <= 1'b0;
        end else begin
            dv_q <= rd_last_on;
            if (rd_last_on) begin
                rdata_q <= mem_data_in;
            end
        end
    end

    assign busy        = active;
    assign mem_rd_n    = rd_n_q;
    assign mem_cs_n    = cs_n_q;
    assign rdata       = rdata_q;
    assign rdata_valid = dv_q;

endmodule

// File: rtl/smem_rd_chk.sv
// Protocol checker for smem_rd_timer, attached by bind. It watches only
// the top-level ports.
module smem_rd_chk #(
    parameter int ADDR_W = 24,
    parameter int NUM_CS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_n,
    input logic [NUM_CS-1:0] mem_cs_n
    ,
    input logic              rdata_valid
);

    // R6
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R5
    rd_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> busy);

    // R6
    cs_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n != '1) |-> busy);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(mem_addr)));

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);

endmodule

bind smem_rd_timer smem_rd_chk #(
    .ADDR_W (ADDR_W),
    .NUM_CS (NUM_CS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .mem_addr    (mem_addr),
    .mem_rd_n    (mem_rd_n),
    .mem_cs_n    (mem_cs_n),
    .rdata_valid (rdata_valid)
);

// File: tb/tb_smem_rd_timer.sv
`timescale 1ns/1ps
module tb_smem_rd_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [2:0]  req_cs = '0;
    logic        cfg_dev16 = 1'b0;
    logic [5:0]  cfg_rd_setup = '0, cfg_rd_pulse = 6'd1, cfg_rd_hold = '0;
    logic [5:0]  cfg_cs_setup = '0, cfg_cs_pulse = 6'd1, cfg_cs_hold = '0;
    logic [5:0]  cfg_cycle = 6'd1;
    logic        busy;
    logic [23:0] mem_addr;
    logic        mem_rd_n;
    logic [5:0]  mem_cs_n;
    logic [15:0] mem_data_in = '0;
    logic [15:0] rdata;
    logic        rdata_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    smem_rd_timer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_cs(req_cs), .cfg_dev16(cfg_dev16),
        .cfg_rd_setup(cfg_rd_setup), .cfg_rd_pulse(cfg_rd_pulse), .cfg_rd_hold(cfg_rd_hold),
        .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse), .cfg_cs_hold(cfg_cs_hold),
        .cfg_cycle(cfg_cycle), .busy(busy), .mem_addr(mem_addr), .mem_rd_n(mem_rd_n),
        .mem_cs_n(mem_cs_n), .mem_data_in(mem_data_in), .rdata(rdata), .rdata_valid(rdata_valid)
    );

    typedef struct packed {
        logic [2:0]  cs;
        logic        d16;
        logic [23:0] addr;
        logic [5:0]  rs, rp, rh, ss, sp, sh, cyc;
        logic        spam;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b0, 24'h123457, 6'd1, 6'd2, 6'd1, 6'd0, 6'd4, 6'd0, 6'd5,  1'b0},
        '{3'd5, 1'b1, 24'hABCDEF, 6'd2, 6'd3, 6'd2, 6'd1, 6'd5, 6'd1, 6'd4,  1'b0},
        '{3'd3, 1'b0, 24'h00F00D, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0,  1'b0},
        '{3'd2, 1'b1, 24'h400002, 6'd3, 6'd1, 6'd0, 6'd2, 6'd3, 6'd4, 6'd10, 1'b0},
        '{3'd1, 1'b0, 24'h5A5A5A, 6'd1, 6'd4, 6'd2, 6'd0, 6'd7, 6'd0, 6'd3,  1'b1},
        '{3'd7, 1'b0, 24'h000123, 6'd1, 6'd1, 6'd1, 6'd0, 6'd3, 6'd0, 6'd3,  1'b0},
        '{3'd4, 1'b1, 24'hFFFFFF, 6'd0, 6'd5, 6'd0, 6'd0, 6'd0, 6'd2, 6'd2,  1'b1},
        '{3'd0, 1'b0, 24'h0C0FFE, 6'd5, 6'd2, 6'd3, 6'd4, 6'd4, 6'd2, 6'd20, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(busy == 1'b0, req, "busy", 32'(busy), 0);
        chk(mem_rd_n == 1'b1, req, "mem_rd_n", 32'(mem_rd_n), 1);
        chk(mem_cs_n == 6'h3F, req, "mem_cs_n", 32'(mem_cs_n), 32'h3F);
        chk(rdata_valid == 1'b0, req, "rdata_valid", 32'(rdata_valid), 0);
    endtask

    // One access from a vector; checks every cycle against the computed windows.
    task automatic run_vec(input vec_t v);
        int rp_e, sp_e, rspan, sspan, len, cap_t, kmax;
        logic [23:0] exp_addr;
        logic [5:0]  exp_cs;
        rp_e  = (v.rp == 0) ? 1 : int'(v.rp);
        sp_e  = (v.sp == 0) ? 1 : int'(v.sp);
        rspan = int'(v.rs) + rp_e + int'(v.rh);
        sspan = int'(v.ss) + sp_e + int'(v.sh);
        len   = (v.cyc == 0) ? 1 : int'(v.cyc);
        if (rspan > len) len = rspan;
        if (sspan > len) len = sspan;
        cap_t = int'(v.rs) + rp_e;
        kmax  = ((cap_t > len) ? cap_t : len) + 2;
        exp_addr = v.d16 ? {1'b0, v.addr[23:1]} : v.addr;
        @(negedge clk);
        cfg_dev16 = v.d16; cfg_cycle = v.cyc;
        cfg_rd_setup = v.rs; cfg_rd_pulse = v.rp; cfg_rd_hold = v.rh;
        cfg_cs_setup = v.ss; cfg_cs_pulse = v.sp; cfg_cs_hold = v.sh;
        req_addr = v.addr; req_cs = v.cs; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k <= kmax; k++) begin
            if (v.spam && k < len - 1) begin
                req_valid = 1'b1; req_addr = ~v.addr; req_cs = v.cs ^ 3'd1;
            end else begin
                req_valid = 1'b0;
            end
            // R2 / R9: busy for exactly len cycles
            chk(busy == (k < len), (rspan > v.cyc || sspan > v.cyc) ? "R9" : "R2",
                "busy", 32'(busy), 32'(k < len));
            // R3 / R4 / R10: address shown from t=0 and held
            chk(mem_addr == exp_addr, v.spam ? "R10" : (v.d16 ? "R4" : "R3"),
                "mem_addr", 32'(mem_addr), 32'(exp_addr));
            // R5 / R7: read strobe window
            chk(mem_rd_n == !(k >= int'(v.rs) && k < int'(v.rs) + rp_e),
                (v.rp == 0) ? "R7" : "R5", "mem_rd_n", 32'(mem_rd_n),
                32'(!(k >= int'(v.rs) && k < int'(v.rs) + rp_e)));
            // R6: chip-select window on the selected line only
            exp_cs = 6'h3F;
            if (v.cs < 3'd6 && k >= int'(v.ss) && k < int'(v.ss) + sp_e)
                exp_cs[v.cs] = 1'b0;
            chk(mem_cs_n == exp_cs, v.spam ? "R10" : "R6", "mem_cs_n",
                32'(mem_cs_n), 32'(exp_cs));
            // R8: capture and one-cycle valid
            chk(rdata_valid == (k == cap_t), "R8", "rdata_valid",
                32'(rdata_valid), 32'(k == cap_t));
            if (k == cap_t)
                chk(rdata == 16'hA000 + 16'(cap_t - 1), "R8", "rdata",
                    32'(rdata), 32'(16'hA000 + 16'(cap_t - 1)));
            mem_data_in = 16'hA000 + 16'(k);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_idle("R1");
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R1: reset in the middle of an access returns all pins to idle
        cfg_rd_setup = 6'd1; cfg_rd_pulse = 6'd6; cfg_rd_hold = 6'd1;
        cfg_cs_setup = 6'd0; cfg_cs_pulse = 6'd8; cfg_cs_hold = 6'd0;
        cfg_cycle = 6'd9; req_cs = 3'd2; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(mem_rd_n == 1'b0, "R5", "mem_rd_n before reset", 32'(mem_rd_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_idle("R1");
        @(negedge clk);
        chk_idle("R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule